// File: doc/BRIEF.md
# Line Mirror Buffer

The block mirrors every scan line of a pixel stream left-to-right. It holds a single memory of one line's size. For every incoming pixel it first reads out the pixel that the previous line left in the target slot, and then overwrites that slot with the new pixel. After each line the address walk changes direction, so the slots of the stored line are always read in the reverse of the order they were written. No second line store is needed.

The block runs from one clock at twice the pixel rate. An internal slot bit splits each pixel period into a read clock and a write clock. Every output line is the previous input line in reverse order, so the block adds one line of latency, and the first line after reset produces no output. Input lines must be exactly `LINE_LEN` pixels long.

Top module: `lrev_buffer`

## Requirements
- R1: While reset is asserted, and after it is released until the first output pixel, `out_valid` and `out_sol` are low and `out_pix` is zero.
- R2: An input beat is taken on a rising edge where `in_valid` is high and the block is in its read slot. The edge after a taken beat is the write slot, and `in_valid`, `in_sol` and `in_pix` are ignored there.
- R3: The first input line after reset, which is the line that opens with the first `in_sol` beat, produces no output pixels.
- R4: Output line k is input line k-1 reversed: output pixel j equals input pixel LINE_LEN-1-j of the previous line, over any number of consecutive lines.
- R5: For a beat taken on edge t, `out_pix` is updated on edge t+1. `out_valid` is then high for exactly the one clock that follows edge t+1 and is low in the clock that follows edge t.
- R6: `out_sol` is high together with `out_valid` on the first output pixel of each line and is low on every other output pixel.
- R7: A line start is a beat with `in_sol` high. It reverses the scan direction: the first line is written at ascending addresses, and each following line starts at the slot the previous line ended on. The first output pixel of a line is therefore the last input pixel of the previous line, even when the two beats are back to back.
- R8: Each taken beat makes exactly two memory accesses. The first is a read, and the second is a write to the same address on the next clock. The address always lies within 0..LINE_LEN-1.
- R9: Idle clocks of any count, even or odd, between beats, including inside a line, do not change the pixels that come out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input pixel present |
| in_sol | input | 1 | Input pixel is the first of its line |
| in_pix | input | PIX_W | Input pixel value |
| out_valid | output | 1 | One-clock strobe per output pixel |
| out_sol | output | 1 | Output pixel is the first of its line |
| out_pix | output | PIX_W | Output pixel value, held between strobes |

## Verification
Two events coincide at every line turn. A line start reverses the scan, and the read of the new line's first beat hits the slot whose write, for the previous line's last beat, happened only one clock earlier. The bench provokes this by streaming lines back to back in both scan directions. It judges the result by whether the first output pixel of each line equals the last pixel sent on the line before. A second collision exists between the write slot and new input held on the bus. This one is provoked by driving corrupt values with `in_valid` still high during write slots, and is judged by outputs that stay unchanged.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

  // which half of the pixel period the memory is serving
  typedef enum logic {
    SLOT_READ  = 1'b0,
    SLOT_WRITE = 1'b1
  } slot_e;

  // walking order of line addresses
  typedef enum logic {
    SCAN_UP   = 1'b0,
    SCAN_DOWN = 1'b1
  } scan_e;

endpackage

// File: rtl/lrb_slot_ctrl.sv
module lrb_slot_ctrl
  import lrb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic take,
  output logic phase_wr
);

  slot_e slot_q;
  slot_e slot_n;

  // stays in the read slot while idle; a taken beat forces one write slot
  always_comb begin
    slot_n = SLOT_READ;
    if (slot_q == SLOT_READ && in_valid) begin
      slot_n = SLOT_WRITE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SLOT_READ;
    end else begin
      slot_q <= slot_n;
    end
  end

  assign take     = in_valid && (slot_q == SLOT_READ);
  assign phase_wr = (slot_q == SLOT_WRITE);

endmodule

// File: rtl/lrb_addr_gen.sv
module lrb_addr_gen
  import lrb_pkg::*;
#(
  parameter int LINE_LEN = 512,
  localparam int AW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          sol,
  output logic [AW-1:0] addr,
  output logic          line_ok
);

  localparam logic [AW-1:0] LAST = AW'(LINE_LEN - 1);

  scan_e         dir_q, dir_n;
  logic [AW-1:0] idx_q, idx_n;
  logic          started_q, started_n;
  logic          stored_q, stored_n;

  always_comb begin
    dir_n     = dir_q;
    addr      = idx_q;
    line_ok   = stored_q;
    started_n = started_q;
    stored_n  = stored_q;
    if (sol) begin
      if (started_q) begin
        dir_n = (dir_q == SCAN_UP) ? SCAN_DOWN : SCAN_UP;
      end else begin
        dir_n = SCAN_UP;
      end
      addr      = (dir_n == SCAN_DOWN) ? LAST : '0;
      line_ok   = started_q;
      started_n = 1'b1;
      stored_n  = started_q;
    end
    if (dir_n == SCAN_DOWN) begin
      idx_n = (addr == '0) ? LAST : addr - 1'b1;
    end else begin
      idx_n = (addr == LAST) ? '0 : addr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= SCAN_UP;
      idx_q     <= '0;
      started_q <= 1'b0;
      stored_q  <= 1'b0;
    end else if (take) begin
      dir_q     <= dir_n;
      idx_q     <= idx_n;
      started_q <= started_n;
      stored_q  <= stored_n;
    end
  end

endmodule

// File: rtl/lrb_line_ram.sv
module lrb_line_ram #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // single port: one read or one write per clock
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[addr] <= wdata;
      end else begin
        rdata <= mem[addr];
      end
    end
  end

endmodule

// File: rtl/lrev_buffer.sv
module lrev_buffer #(
  parameter int LINE_LEN = 512,
  parameter int PIX_W    = 8,
  localparam int AW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sol,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  output logic             out_sol,
  output logic [PIX_W-1:0] out_pix
);

  logic [1:0]       rst_q;
  logic             rst_sync_n;
  logic             take;
  logic             phase_wr;
  logic [AW-1:0]    ag_addr;
  logic             ag_ok;
  logic [AW-1:0]    cap_addr;
  logic [PIX_W-1:0] cap_pix;
  logic             cap_sol;
  logic             cap_ok;
  logic             ram_en;
  logic             ram_we;
  logic [AW-1:0]    ram_addr;
  logic [PIX_W-1:0] ram_rdata;
  logic             emit;

  // reset asserts at once, releases after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= '0;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_q[1];

  lrb_slot_ctrl u_slot (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .take     (take),
    .phase_wr (phase_wr)
  );

  lrb_addr_gen #(.LINE_LEN(LINE_LEN)) u_addr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .take    (take),
    .sol     (in_sol),
    .addr    (ag_addr),
    .line_ok (ag_ok)
  );

  // beat capture for the write slot
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cap_addr <= '0;
      cap_pix  <= '0;
      cap_sol  <= 1'b0;
      cap_ok   <= 1'b0;
    end else if (take) begin
      cap_addr <= ag_addr;
      cap_pix  <= in_pix;
      cap_sol  <= in_sol;
      cap_ok   <= ag_ok;
    end
  end

  assign ram_en   = take || phase_wr;
  assign ram_we   = phase_wr;
  assign ram_addr = phase_wr ? cap_addr : ag_addr;

  lrb_line_ram #(.DEPTH(LINE_LEN), .WIDTH(PIX_W)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (cap_pix),
    .rdata (ram_rdata)
  );

  assign emit = phase_wr && cap_ok;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
    end else begin
      out_valid <= emit;
      out_sol   <= emit && cap_sol;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_pix <= '0;
    end else if (emit) begin
      out_pix <= ram_rdata;
    end
  end

endmodule

// File: rtl/lrev_buffer_sva.sv
module lrev_buffer_sva #(
  parameter int LINE_LEN = 512,
  localparam int AW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_sol,
  input logic          phase_wr,
  input logic          ram_en,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic          out_valid,
  input logic          out_sol
);

  logic [1:0] sol_seen;

  // count line starts taken since reset, saturating at two
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sol_seen <= '0;
    end else if (in_valid && in_sol && !phase_wr && sol_seen != 2'd2) begin
      sol_seen <= sol_seen + 2'd1;
    end
  end

  assert_first_line_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> sol_seen == 2'd2);

  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_write_follows_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_wr |-> $past(in_valid && !phase_wr));

  assert_read_before_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(ram_en && !ram_we));

  assert_same_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_addr == $past(ram_addr));

  assert_addr_in_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> {1'b0, ram_addr} < (AW+1)'(LINE_LEN));

  assert_sol_has_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_sol |-> out_valid);

endmodule

bind lrev_buffer lrev_buffer_sva #(.LINE_LEN(LINE_LEN)) u_sva (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_sol    (in_sol),
  .phase_wr  (phase_wr),
  .ram_en    (ram_en),
  .ram_we    (ram_we),
  .ram_addr  (ram_addr),
  .out_valid (out_valid),
  .out_sol   (out_sol)
);

// File: tb/test_lrev_buffer.sv
`timescale 1ns/1ps
module test_lrev_buffer;

  localparam int LEN = 12;
  localparam int PW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_sol = 1'b0;
  logic [PW-1:0] in_pix = '0;
  logic          out_valid;
  logic          out_sol;
  logic [PW-1:0] out_pix;

  int checks = 0;
  int fails  = 0;
  logic [PW-1:0] prev_line [LEN];
  logic [PW-1:0] cur_line  [LEN];
  bit has_prev = 1'b0;

  always #2.5 clk = ~clk;

  lrev_buffer #(.LINE_LEN(LEN), .PIX_W(PW)) i_lrev_buffer (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sol    (in_sol),
    .in_pix    (in_pix),
    .out_valid (out_valid),
    .out_sol   (out_sol),
    .out_pix   (out_pix)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one beat held for two clocks; result sampled after the write slot
  task automatic send_beat(input logic [PW-1:0] pix, input bit sol, input int j,
                           input bit garbage, input int gap, input string req);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
    in_valid = 1'b1;
    in_sol   = sol;
    in_pix   = pix;
    @(negedge clk);
    chk(out_valid == 1'b0, "R5", "valid low before write slot", out_valid, 0);
    if (garbage) begin
      in_pix = ~pix;
      in_sol = ~sol;
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (has_prev) begin
      chk(out_valid == 1'b1, req, "valid strobe", out_valid, 1);
      chk(out_pix == prev_line[LEN-1-j], req, "mirrored pixel", out_pix, prev_line[LEN-1-j]);
      chk(out_sol == (j == 0), "R6", "line start marker", out_sol, (j == 0));
      if (j == 0) begin
        chk(out_pix == prev_line[LEN-1], "R7", "turn pixel", out_pix, prev_line[LEN-1]);
      end
    end else begin
      chk(out_valid == 1'b0, "R3", "no output on first line", out_valid, 0);
    end
    cur_line[j] = pix;
  endtask

  task automatic send_line(input int line, input bit garbage, input int gap,
                           input string req);
    for (int j = 0; j < LEN; j++) begin
      send_beat(PW'(line * 37 + j * 5 + 1), (j == 0), j, garbage,
                (j == 0) ? 0 : gap, req);
    end
    for (int j = 0; j < LEN; j++) prev_line[j] = cur_line[j];
    has_prev = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_sol   = 1'b0;
    has_prev = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
    chk(out_sol == 1'b0, "R1", "sol in reset", out_sol, 0);
    chk(out_pix == '0, "R1", "pixel in reset", out_pix, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "valid after release", out_valid, 0);
    chk(out_pix == '0, "R1", "pixel after release", out_pix, 0);
  endtask

  // R3 then R4/R7: back-to-back lines in both directions
  task automatic t_stream();
    send_line(0, 1'b0, 0, "R3");
    for (int k = 1; k <= 4; k++) send_line(k, 1'b0, 0, "R4");
  endtask

  // R2: corrupt bus during write slots; R9: odd and even idle gaps
  task automatic t_bus_noise_and_gaps();
    send_line(5, 1'b1, 0, "R2");
    send_line(6, 1'b0, 1, "R9");
    send_line(7, 1'b1, 3, "R9");
    send_line(8, 1'b0, 2, "R2");
  endtask

  // reset in mid stream: first line again quiet, then R4 resumes
  task automatic t_reset_mid();
    for (int j = 0; j < 5; j++) send_beat(PW'(j + 200), (j == 0), j, 1'b0, 0, "R4");
    do_reset();
    send_line(9, 1'b0, 0, "R3");
    send_line(10, 1'b0, 0, "R4");
    send_line(11, 1'b0, 1, "R4");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    t_stream();
    t_bus_noise_and_gaps();
    t_reset_mid();
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R5", "idle valid", out_valid, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule